// File: doc/BRIEF.md
# Coherent Interconnect Routing Table

This block is the routing table of one node in a small coherent multiprocessor fabric of up to eight nodes. Each node has three links and a local port. For every packet, the fabric logic presents the destination node number and the packet class. One clock later the table returns a 4-bit port mask that says where the packet goes.

Each destination row holds three independent masks: one for requests, one for responses and one for broadcasts. Firmware programs the rows and a control register through a plain 32-bit register write port with a combinational read-back. Until the routes are set up, a control bit makes the table bypass its rows and send every packet to a fixed default link. That link is chosen by strap pins and is visible read-only in the control register. A second control bit holds back request traffic. The control register also has scratch flags that tell a cold start from a warm restart. A node-number register starts at the highest node number, which marks a node that has not yet been given its own number.

Top module: `coh_route_table`

## Requirements
- R1: Both resets set every row to 0x00010101. In that value the request mask (bits [3:0]), the response mask (bits [11:8]) and the broadcast mask (bits [19:16]) each select only the local port.
- R2: Row N is written and read at byte address 0x40 + 4*N. A write stores bits [3:0], [11:8] and [19:16]. Reads return zero in all other bits, and at any address that is not mapped.
- R3: The lookup class is 0 for request, 1 for response, 2 for broadcast and 3 for none. The port mask that the lookup selects appears one clock after the inputs are sampled. Class 3 gives mask 0. In a mask, bit 0 is the local port and bits 1, 2 and 3 are links 0, 1 and 2. A mask may have more than one bit set.
- R4: A row write is seen by a lookup sampled in the cycle after the write. A lookup sampled in the same cycle as the write still sees the old row.
- R5: While control bit 0 (table off) is set, every class other than 3 gives a one-hot mask taken from the default link. Value 0 gives bit 1, value 1 gives bit 2, value 2 gives bit 3 and value 3 gives bit 0 (local).
- R6: While control bit 1 (requests held) is set, a request lookup gives mask 0. Response and broadcast lookups are not affected.
- R7: Control bits [3:2] at address 0x6C always read the default-link strap input. Writes to these bits are ignored.
- R8: Control bits 4 and 5 are scratch flags. A warm reset leaves them unchanged and only a cold reset clears them. Control bit 6 is a scratch flag that either reset clears.
- R9: The node number sits in bits [2:0] of address 0x60 and is driven on an output port. Either reset sets it to 7.
- R10: After either reset, control bits 0 and 1 are both set, so the table is bypassed and requests are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_cold_n | input | 1 | Cold reset, active low, synchronous |
| rst_warm_n | input | 1 | Warm reset, active low, synchronous |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| dflt_link | input | 2 | Default-link strap |
| lk_dest | input | 3 | Lookup destination node |
| lk_cls | input | 2 | Lookup class |
| port_mask | output | 4 | Registered output port mask |
| node_id | output | 3 | Node number register value |

## Verification
Every row gets a different value, so a mix-up of rows or classes shows up as a wrong mask. Each row is then looked up in all four classes, with broadcast masks that have several bits set. The bypass path is tried with all four strap values and two classes, which separates a correct one-hot decode from a shifted or inverted one. Request hold is tried with the table both on and off, to tell it apart from bypass. A write issued together with a lookup of the same row confirms that the old row value is returned in that cycle and the new one in the next. Warm and cold resets are applied after the scratch flags are set, which tells apart which flags each reset clears.

// File: rtl/coh_route_table.sv
module coh_route_table #(
  parameter int          NODES    = 8,
  parameter int          PORTS    = 4,
  parameter logic [7:0]  ROW_BASE = 8'h40,
  parameter logic [7:0]  NID_ADDR = 8'h60,
  parameter logic [7:0]  CTL_ADDR = 8'h6C,
  localparam int         ID_W     = $clog2(NODES)
) (
  input  logic              clk,
  input  logic              rst_cold_n,
  input  logic              rst_warm_n,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [1:0]        dflt_link,
  input  logic [ID_W-1:0]   lk_dest,
  input  logic [1:0]        lk_cls,
  output logic [PORTS-1:0]  port_mask,
  output logic [ID_W-1:0]   node_id
);
  localparam logic [PORTS-1:0] LOCAL_ONLY = PORTS'(1);

  logic any_rst;
  assign any_rst = !rst_cold_n || !rst_warm_n;

  logic unused_wdata;
  assign unused_wdata = ^cfg_wdata;

  logic [PORTS-1:0] rq_a [NODES];
  logic [PORTS-1:0] rs_a [NODES];
  logic [PORTS-1:0] bc_a [NODES];
  logic [31:0]      row_rd [NODES];

  for (genvar g = 0; g < NODES; g++) begin : g_row
    logic [PORTS-1:0] rq_q, rs_q, bc_q;
    logic hit;
    assign hit = cfg_wr && (cfg_addr == 8'(ROW_BASE + 4*g));
    always_ff @(posedge clk) begin
      if (any_rst) begin
        rq_q <= LOCAL_ONLY;
        rs_q <= LOCAL_ONLY;
        bc_q <= LOCAL_ONLY;
      end else if (hit) begin
        rq_q <= cfg_wdata[PORTS-1:0];
        rs_q <= cfg_wdata[8 +: PORTS];
        bc_q <= cfg_wdata[16 +: PORTS];
      end
    end
    assign rq_a[g]   = rq_q;
    assign rs_a[g]   = rs_q;
    assign bc_a[g]   = bc_q;
    assign row_rd[g] = (32'(bc_q) << 16) | (32'(rs_q) << 8) | 32'(rq_q);
  end

  logic tbl_off_q, req_off_q, cold_flag_q, boot_flag_q, init_flag_q;
  logic ctl_hit, nid_hit;
  assign ctl_hit = cfg_wr && (cfg_addr == CTL_ADDR);
  assign nid_hit = cfg_wr && (cfg_addr == NID_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_cold_n) begin
      tbl_off_q   <= 1'b1;
      req_off_q   <= 1'b1;
      cold_flag_q <= 1'b0;
      boot_flag_q <= 1'b0;
      init_flag_q <= 1'b0;
    end else if (!rst_warm_n) begin
      tbl_off_q   <= 1'b1;
      req_off_q   <= 1'b1;
      init_flag_q <= 1'b0;
    end else if (ctl_hit) begin
      tbl_off_q   <= cfg_wdata[0];
      req_off_q   <= cfg_wdata[1];
      cold_flag_q <= cfg_wdata[4];
      boot_flag_q <= cfg_wdata[5];
      init_flag_q <= cfg_wdata[6];
    end
  end

  always_ff @(posedge clk) begin
    if (any_rst)      node_id <= '1;
    else if (nid_hit) node_id <= cfg_wdata[ID_W-1:0];
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == CTL_ADDR)
      cfg_rdata = {25'd0, init_flag_q, boot_flag_q, cold_flag_q, dflt_link, req_off_q, tbl_off_q};
    else if (cfg_addr == NID_ADDR)
      cfg_rdata = 32'(node_id);
    for (int r = 0; r < NODES; r++)
      if (cfg_addr == 8'(ROW_BASE + 4*r)) cfg_rdata = row_rd[r];
  end

  logic [PORTS-1:0] dflt_mask, mask_d;
  assign dflt_mask = (dflt_link == 2'd3) ? LOCAL_ONLY : (PORTS'(2) << dflt_link);

  always_comb begin
    case (lk_cls)
      2'd0:    mask_d = rq_a[lk_dest];
      2'd1:    mask_d = rs_a[lk_dest];
      2'd2:    mask_d = bc_a[lk_dest];
      default: mask_d = '0;
    endcase
    if (tbl_off_q && lk_cls != 2'd3) mask_d = dflt_mask;
    if (req_off_q && lk_cls == 2'd0) mask_d = '0;
  end

  always_ff @(posedge clk) begin
    if (any_rst) port_mask <= '0;
    else         port_mask <= mask_d;
  end

  assert_cls_none_R3: assert property (@(posedge clk) disable iff (any_rst)
    (lk_cls == 2'd3) |=> (port_mask == '0))
    else $error("class 3 produced a nonzero mask");

  assert_bypass_onehot_R5: assert property (@(posedge clk) disable iff (any_rst)
    (tbl_off_q && lk_cls != 2'd3 && !(req_off_q && lk_cls == 2'd0)) |=> ($countones(port_mask) == 1))
    else $error("bypass mask not one-hot");

  assert_req_held_R6: assert property (@(posedge clk) disable iff (any_rst)
    (req_off_q && lk_cls == 2'd0) |=> (port_mask == '0))
    else $error("request routed while held");

  assert_warm_keeps_R8: assert property (@(posedge clk) disable iff (!rst_cold_n)
    (!rst_warm_n) |=> ({boot_flag_q, cold_flag_q} == $past({boot_flag_q, cold_flag_q}) && !init_flag_q))
    else $error("warm reset disturbed scratch flags");

  assert_nid_reset_R9: assert property (@(posedge clk) disable iff (!rst_cold_n)
    (!rst_warm_n) |=> (node_id == '1))
    else $error("node number not restored by warm reset");

  assert_ctl_reset_R10: assert property (@(posedge clk) disable iff (!rst_cold_n)
    (!rst_warm_n) |=> (tbl_off_q && req_off_q))
    else $error("control bits not restored by reset");
endmodule

// File: tb/coh_route_table_tb.sv
module coh_route_table_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] CTL = 8'h6C, NID = 8'h60;

  logic clk = 0, rst_cold_n = 0, rst_warm_n = 1, cfg_wr = 0;
  logic [7:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic [1:0]  dflt_link = 2'd2, lk_cls = 2'd3;
  logic [2:0]  lk_dest = 0, node_id;
  logic [3:0]  port_mask;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] model [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  coh_route_table dut_i (.clk, .rst_cold_n, .rst_warm_n, .cfg_wr, .cfg_addr, .cfg_wdata,
    .cfg_rdata, .dflt_link, .lk_dest, .lk_cls, .port_mask, .node_id);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 0;
    if (a >= 8'h40 && a < 8'h60 && a[1:0] == 0) model[(a - 8'h40) >> 2] = d & 32'h000F0F0F;
  endtask

  task automatic rd(string req, logic [7:0] a, logic [31:0] exp);
    @(negedge clk); cfg_addr = a; #1; chk(req, cfg_rdata, exp);
  endtask

  task automatic look(string req, logic [2:0] d, logic [1:0] c, logic [3:0] exp);
    @(negedge clk); lk_dest = d; lk_cls = c;
    @(negedge clk); chk(req, 32'(port_mask), 32'(exp));
  endtask

  function automatic logic [3:0] field(logic [31:0] row, logic [1:0] c);
    case (c)
      2'd0: return row[3:0];
      2'd1: return row[11:8];
      2'd2: return row[19:16];
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic [3:0] onehot_of(logic [1:0] l);
    return (l == 2'd3) ? 4'b0001 : (4'b0010 << l);
  endfunction

  task automatic do_reset(bit cold);
    @(negedge clk); if (cold) rst_cold_n = 0; else rst_warm_n = 0;
    repeat (2) @(negedge clk);
    rst_cold_n = 1; rst_warm_n = 1;
    for (int i = 0; i < 8; i++) model[i] = 32'h00010101;
  endtask

  task automatic t_reset_state;
    do_reset(1);
    for (int i = 0; i < 8; i++) rd("R1 row default", 8'(8'h40 + 4*i), 32'h00010101);
    rd("R10 control after reset", CTL, 32'h0000000B);
    rd("R9 node id after reset", NID, 32'd7);
    chk("R9 node id port", 32'(node_id), 32'd7);
    chk("R3 mask after reset", 32'(port_mask), 0);
  endtask

  task automatic t_rows;
    for (int i = 0; i < 8; i++)
      wr(8'(8'h40 + 4*i), 32'hFFF0F0F0 | 32'((i*3+1) & 15) | (32'((i+5) & 15) << 8) | (32'((15 - i) & 15) << 16));
    for (int i = 0; i < 8; i++) rd("R2 row readback", 8'(8'h40 + 4*i), model[i]);
    rd("R2 unmapped reads zero", 8'h20, 0);
    rd("R2 misaligned reads zero", 8'h42, 0);
  endtask

  task automatic t_lookup;
    wr(CTL, 0);
    for (int d = 0; d < 8; d++)
      for (int c = 0; c < 4; c++)
        look("R3 table lookup", 3'(d), 2'(c), field(model[d], 2'(c)));
  endtask

  task automatic t_same_cycle;
    logic [3:0] old_v = model[3][3:0];
    @(negedge clk); cfg_wr = 1; cfg_addr = 8'h4C; cfg_wdata = 32'h00020406; lk_dest = 3; lk_cls = 0;
    @(negedge clk); cfg_wr = 0;
    chk("R4 same-cycle sees old row", 32'(port_mask), 32'(old_v));
    model[3] = 32'h00020406;
    @(negedge clk);
    chk("R4 next cycle sees new row", 32'(port_mask), 32'h6);
  endtask

  task automatic t_bypass;
    wr(CTL, 1);
    for (int l = 0; l < 4; l++) begin
      dflt_link = 2'(l);
      look("R5 bypass broadcast", 3'd5, 2'd2, onehot_of(2'(l)));
      look("R5 bypass response", 3'd1, 2'd1, onehot_of(2'(l)));
    end
    look("R3 bypass class none", 3'd1, 2'd3, 0);
    dflt_link = 2'd2;
  endtask

  task automatic t_req_hold;
    wr(CTL, 2);
    look("R6 request held", 3'd2, 2'd0, 0);
    look("R6 response passes", 3'd2, 2'd1, field(model[2], 2'd1));
    look("R6 broadcast passes", 3'd6, 2'd2, field(model[6], 2'd2));
    wr(CTL, 3);
    look("R6 request held in bypass", 3'd2, 2'd0, 0);
  endtask

  task automatic t_dflt_ro;
    dflt_link = 2'd1;
    wr(CTL, 32'h0000000C);
    rd("R7 default link read-only", CTL, 32'h00000004);
    dflt_link = 2'd2;
  endtask

  task automatic t_scratch_nid;
    wr(NID, 32'hFFFFFFF5);
    rd("R9 node id write", NID, 32'd5);
    chk("R9 node id port", 32'(node_id), 32'd5);
    wr(8'h48, 32'h00080808);
    wr(CTL, 32'h00000070);
    rd("R8 scratch written", CTL, 32'h00000078);
    do_reset(0);
    rd("R8 warm keeps 4,5 clears 6", CTL, 32'h0000003B);
    rd("R1 row default after warm", 8'h48, 32'h00010101);
    rd("R9 node id after warm", NID, 32'd7);
    do_reset(1);
    rd("R8 cold clears all flags", CTL, 32'h0000000B);
  endtask

  initial begin
    t_reset_state;
    t_rows;
    t_lookup;
    t_same_cycle;
    t_bypass;
    t_req_hold;
    t_dflt_ro;
    t_scratch_nid;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule